// File: doc/BRIEF.md
# Flash Erase Unlock and Write-Steering Controller

This block sits between an 8-bit register bus and an on-chip flash array. It allows an erase only after a fixed unlock sequence. A whole-array erase needs two things. First, an arming bit must be set in the control register. Second, the byte 0xAA must then be written to the erase register while the debug-port-enable input is high. A single-page erase needs only the byte 0x55 written to the erase register, and the page comes from the page register. Any other byte written to the erase register launches nothing and disarms the whole-array erase.

Once an erase starts, the block raises a one-cycle request together with its scope: the whole array, or the base byte address of one page. It then holds busy for a programmable number of cycles and pulses done at the end. The block also steers external-data write strobes. When the program-write-enable bit is set they go to the flash, otherwise they go to data RAM. Flash strobes are blocked while an erase runs.

Top module: `flash_erase_ctl`

## Requirements
- R1: With the arming bit (control register bit 1) set and `dbg_en` high, writing 0xAA to the erase register (address 2) gives `erase_req` high for one cycle, starting the cycle after the write, with `erase_all` high.
- R2: A 0xAA write while `dbg_en` is low launches nothing and clears the arming bit.
- R3: Writing 0x55 to the erase register gives a one-cycle `erase_req` with `erase_all` low and `erase_addr` equal to page-register bits 7:1 shifted left by 9. Page-register bit 0 is ignored.
- R4: Writing any other byte, or 0xAA with the arming bit clear, launches nothing and clears the arming bit.
- R5: The arming bit reads back as 0 once a whole-array erase has launched.
- R6: After a launch, `busy` stays high for exactly `erase_cycles` cycles, with 0 treated as 1. `done` is high for the one cycle in which `busy` first reads low.
- R7: A write to the erase register while `busy` is high launches nothing and leaves the arming bit unchanged.
- R8: `fl_wr` follows `xd_wr` when program-write-enable (control bit 0) is 1. `ram_wr` follows `xd_wr` when that bit is 0. The two are never high together.
- R9: `fl_wr` stays low while `busy` is high.
- R10: `rdata` is combinational on `reg_addr`. Address 0 gives {5'b0, busy, arming bit, program-write-enable}. Address 1 gives {page, 1'b0}. Addresses 2 and 3 give 0.
- R11: After reset, all registers read 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| dbg_en | input | 1 | Debug port enabled; gates whole-array erase |
| erase_cycles | input | 16 | Erase duration in cycles |
| xd_wr | input | 1 | External-data write strobe from the core |
| fl_wr | output | 1 | Write strobe steered to flash |
| ram_wr | output | 1 | Write strobe steered to data RAM |
| erase_req | output | 1 | One-cycle erase launch |
| erase_all | output | 1 | Launch covers the whole array |
| erase_addr | output | 16 | Base byte address of the page to erase |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is an erase-register write that arrives while busy is high and the arming bit is already set. Only that case shows that the write is dropped without disarming. A directed sequence reaches it by launching a long page erase, arming during it, and then writing 0xAA. Random traffic then mixes arming, magic bytes and short durations, so that launches, disarming writes and end-of-erase cycles land next to each other. A cycle-level model in the bench predicts every output.

// File: rtl/flash_ec_pkg.sv
// Shared constants for the flash erase controller: register addresses,
// unlock bytes and control-register bit positions.
package flash_ec_pkg;
    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_PAGE  = 2'd1;
    localparam logic [1:0] A_ERASE = 2'd2;

    localparam logic [7:0] KEY_ALL  = 8'hAA;
    localparam logic [7:0] KEY_PAGE = 8'h55;

    localparam int CB_PWE  = 0;
    localparam int CB_ARM  = 1;
    localparam int CB_BUSY = 2;
endpackage

// File: rtl/flash_ec_regs.sv
// Control and page registers plus the read mux.
// Assumes PAGE_W <= 8; the page field is left-aligned in the byte.
module flash_ec_regs
    import flash_ec_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              clr_arm,
    input  logic              busy,
    output logic              pwe,
    output logic              arm,
    output logic [PAGE_W-1:0] page,
    output logic [7:0]        rdata
);
    localparam int PAD = 8 - PAGE_W;

    // Register writes; an erase-register write clears the arm bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwe  <= 1'b0;
            arm  <= 1'b0;
            page <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) begin
                pwe <= reg_wdata[CB_PWE];
                arm <= reg_wdata[CB_ARM];
            end
            if (reg_wr && reg_addr == A_PAGE)
                page <= reg_wdata[7 -: PAGE_W];
            if (clr_arm)
                arm <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                rdata[CB_PWE]  = pwe;
                rdata[CB_ARM]  = arm;
                rdata[CB_BUSY] = busy;
            end
            A_PAGE:  rdata = 8'(page) << PAD;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/flash_ec_seq.sv
// Unlock decode and erase timer. A launch is decided in the write cycle;
// the request, scope and busy appear one cycle later.
module flash_ec_seq
    import flash_ec_pkg::*;
#(
    parameter int FA_W   = 16,
    parameter int PAGE_W = 7,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              arm,
    input  logic              dbg_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [CNT_W-1:0]  erase_cycles,
    output logic              clr_arm,
    output logic              busy,
    output logic              done,
    output logic              erase_req,
    output logic              erase_all,
    output logic [FA_W-1:0]   erase_addr
);
    localparam int OFF = FA_W - PAGE_W;

    logic             key_wr, go_all, go_page;
    logic [CNT_W-1:0] cnt;

    // Decode an accepted erase-register write into a launch.
    always_comb begin
        key_wr  = reg_wr && reg_addr == A_ERASE && !busy;
        go_all  = key_wr && reg_wdata == KEY_ALL && arm && dbg_en;
        go_page = key_wr && reg_wdata == KEY_PAGE;
        clr_arm = key_wr;
    end

    // Launch capture and countdown of the erase window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            erase_req  <= 1'b0;
            erase_all  <= 1'b0;
            erase_addr <= '0;
            cnt        <= '0;
        end else begin
            erase_req <= go_all || go_page;
            done      <= busy && cnt == CNT_W'(1);
            if (go_all || go_page) begin
                busy       <= 1'b1;
                cnt        <= (erase_cycles == '0) ? CNT_W'(1) : erase_cycles;
                erase_all  <= go_all;
                erase_addr <= go_page ? (FA_W'(page) << OFF) : '0;
            end else if (busy) begin
                if (cnt == CNT_W'(1))
                    busy <= 1'b0;
                else
                    cnt <= cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/flash_ec_route.sv
// Steers external-data write strobes to flash or RAM.
// Flash strobes are held off while an erase is running.
module flash_ec_route (
    input  logic xd_wr,
    input  logic pwe,
    input  logic busy,
    output logic fl_wr,
    output logic ram_wr
);
    // Strobe steering.
    always_comb begin
        fl_wr  = xd_wr && pwe && !busy;
        ram_wr = xd_wr && !pwe;
    end
endmodule

// File: rtl/flash_erase_ctl.sv
// Top of the flash erase controller: registers, unlock sequencer and
// write-strobe steering. Assumes a byte-addressed array of 2**FA_W bytes.
module flash_erase_ctl #(
    parameter int FA_W       = 16,
    parameter int PAGE_BYTES = 512,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       rdata,
    input  logic             dbg_en,
    input  logic [CNT_W-1:0] erase_cycles,
    input  logic             xd_wr,
    output logic             fl_wr,
    output logic             ram_wr,
    output logic             erase_req,
    output logic             erase_all,
    output logic [FA_W-1:0]  erase_addr,
    output logic             busy,
    output logic             done
);
    localparam int PAGE_LOG = $clog2(PAGE_BYTES);
    localparam int PAGE_W   = FA_W - PAGE_LOG;

    logic              pwe, arm, clr_arm;
    logic [PAGE_W-1:0] page;

    flash_ec_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .clr_arm(clr_arm), .busy(busy),
        .pwe(pwe), .arm(arm), .page(page), .rdata(rdata)
    );

    flash_ec_seq #(.FA_W(FA_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .arm(arm), .dbg_en(dbg_en), .page(page),
        .erase_cycles(erase_cycles), .clr_arm(clr_arm), .busy(busy),
        .done(done), .erase_req(erase_req), .erase_all(erase_all),
        .erase_addr(erase_addr)
    );

    flash_ec_route u_route (
        .xd_wr(xd_wr), .pwe(pwe), .busy(busy), .fl_wr(fl_wr), .ram_wr(ram_wr)
    );
endmodule

// File: rtl/flash_erase_ctl_chk.sv
// Temporal checks on the flash erase controller, bound to every instance.
module flash_erase_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic dbg_en,
    input logic xd_wr,
    input logic fl_wr,
    input logic ram_wr,
    input logic erase_req,
    input logic erase_all,
    input logic busy,
    input logic done,
    input logic arm
);
    // R1
    all_needs_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_all) |-> $past(dbg_en));
    // R5
    arm_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_all) |-> !arm);
    // R6
    done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R6
    req_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> busy);
    // R7
    no_req_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !$past(busy));
    // R8
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_wr, ram_wr}));
    // R8
    route_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_wr && !busy) |-> (fl_wr || ram_wr));
    // R9
    no_flash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fl_wr);
endmodule

bind flash_erase_ctl flash_erase_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .xd_wr(xd_wr),
    .fl_wr(fl_wr), .ram_wr(ram_wr), .erase_req(erase_req),
    .erase_all(erase_all), .busy(busy), .done(done), .arm(arm)
);

// File: tb/flash_erase_ctl_tb.sv
// Bench: a cycle model predicts every output; directed corner cases first,
// then seeded random traffic.
module flash_erase_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  rdata;
    logic        dbg_en = 1'b0;
    logic [15:0] erase_cycles = '0;
    logic        xd_wr = 1'b0;
    logic        fl_wr, ram_wr, erase_req, erase_all, busy, done;
    logic [15:0] erase_addr;

    int total = 0;
    int bad = 0;

    // model state
    logic        m_pwe = 0, m_arm = 0, m_busy = 0, m_req = 0, m_all = 0, m_done = 0;
    logic [6:0]  m_page = '0;
    logic [15:0] m_cnt = '0, m_addr = '0;

    always #4 clk = ~clk;

    flash_erase_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rdata(rdata), .dbg_en(dbg_en),
        .erase_cycles(erase_cycles), .xd_wr(xd_wr), .fl_wr(fl_wr),
        .ram_wr(ram_wr), .erase_req(erase_req), .erase_all(erase_all),
        .erase_addr(erase_addr), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {5'b0, m_busy, m_arm, m_pwe};
            2'd1:    return {m_page, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    // One cycle: drive at negedge, compare with the model, advance at posedge.
    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic x, input logic g, input logic [15:0] l);
        logic kw, ga, gp;
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; xd_wr = x; dbg_en = g; erase_cycles = l;
        #1;
        chk("R10 rdata", 16'(rdata), 16'(m_rd(a)));
        chk("R6 busy", 16'(busy), 16'(m_busy));
        chk("R6 done", 16'(done), 16'(m_done));
        chk("R1 R3 erase_req", 16'(erase_req), 16'(m_req));
        if (m_req) begin
            chk("R1 R3 erase_all", 16'(erase_all), 16'(m_all));
            chk("R3 erase_addr", erase_addr, m_addr);
        end
        chk("R8 R9 fl_wr", 16'(fl_wr), 16'(x && m_pwe && !m_busy));
        chk("R8 ram_wr", 16'(ram_wr), 16'(x && !m_pwe));
        @(posedge clk);
        kw = w && a == 2'd2 && !m_busy;
        ga = kw && d == 8'hAA && m_arm && g;
        gp = kw && d == 8'h55;
        m_done = m_busy && m_cnt == 16'd1;
        m_req  = ga || gp;
        if (w && a == 2'd0) begin m_pwe = d[0]; m_arm = d[1]; end
        if (w && a == 2'd1) m_page = d[7:1];
        if (kw) m_arm = 1'b0;
        if (ga || gp) begin
            m_busy = 1'b1;
            m_cnt  = (l == 16'd0) ? 16'd1 : l;
            m_all  = ga;
            m_addr = gp ? {m_page, 9'b0} : 16'h0;
        end else if (m_busy) begin
            if (m_cnt == 16'd1) m_busy = 1'b0;
            else m_cnt = m_cnt - 16'd1;
        end
    endtask

    task automatic idle(input int n, input logic [1:0] a);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 8'h00, 1'b0, 1'b1, 16'd1);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        #1;
        chk("R11 rdata", 16'(rdata), 16'h0);
        chk("R11 outputs", 16'({erase_req, busy, done, fl_wr, ram_wr}), 16'h0);
        rst_n = 1'b1;
        idle(1, 2'd1);

        // R1 + R5: arm, then whole-array key
        cyc(1, 2'd0, 8'h02, 0, 1, 16'd3);
        cyc(1, 2'd2, 8'hAA, 0, 1, 16'd3);
        #1 chk("R1 req", 16'(erase_req), 16'h1);
        chk("R1 all", 16'(erase_all), 16'h1);
        cyc(0, 2'd0, 8'h00, 0, 1, 16'd3);
        #1 chk("R5 arm bit", 16'(rdata[1]), 16'h0);
        chk("R6 busy bit", 16'(rdata[2]), 16'h1);
        idle(3, 2'd0);

        // R2: debug port disabled
        cyc(1, 2'd0, 8'h02, 0, 1, 16'd2);
        cyc(1, 2'd2, 8'hAA, 0, 0, 16'd2);
        #1 chk("R2 req", 16'(erase_req), 16'h0);
        cyc(0, 2'd0, 8'h00, 0, 1, 16'd2);
        #1 chk("R2 arm bit", 16'(rdata[1]), 16'h0);

        // R4: wrong byte, and 0xAA without arming
        cyc(1, 2'd0, 8'h02, 0, 1, 16'd2);
        cyc(1, 2'd2, 8'h12, 0, 1, 16'd2);
        #1 chk("R4 req", 16'(erase_req), 16'h0);
        cyc(0, 2'd0, 8'h00, 0, 1, 16'd2);
        #1 chk("R4 arm bit", 16'(rdata[1]), 16'h0);
        cyc(1, 2'd2, 8'hAA, 0, 1, 16'd2);
        #1 chk("R4 unarmed req", 16'(erase_req), 16'h0);

        // R3: page erase, bit 0 of the page register set and ignored
        cyc(1, 2'd1, 8'h0B, 0, 1, 16'd5);
        cyc(1, 2'd2, 8'h55, 0, 1, 16'd5);
        #1 chk("R3 req", 16'(erase_req), 16'h1);
        chk("R3 all", 16'(erase_all), 16'h0);
        chk("R3 addr", erase_addr, 16'h0A00);
        // R7: arm then key while busy
        cyc(1, 2'd0, 8'h02, 0, 1, 16'd5);
        cyc(1, 2'd2, 8'hAA, 0, 1, 16'd5);
        #1 chk("R7 req", 16'(erase_req), 16'h0);
        cyc(0, 2'd0, 8'h00, 0, 1, 16'd5);
        #1 chk("R7 arm kept", 16'(rdata[1]), 16'h1);
        cyc(0, 2'd1, 8'h00, 0, 1, 16'd5);
        #1 chk("R10 page read", 16'(rdata), 16'h000A);
        idle(4, 2'd0);

        // R6: zero length acts as one cycle
        cyc(1, 2'd2, 8'h55, 0, 1, 16'd0);
        #1 chk("R6 busy len0", 16'(busy), 16'h1);
        cyc(0, 2'd0, 8'h00, 0, 1, 16'd0);
        #1 chk("R6 done len0", 16'(done), 16'h1);
        chk("R6 busy drop", 16'(busy), 16'h0);

        // R8 / R9 steering
        cyc(1, 2'd0, 8'h01, 0, 1, 16'd4);
        cyc(0, 2'd0, 8'h00, 1, 1, 16'd4);
        #1 chk("R8 flash", 16'({fl_wr, ram_wr}), 16'h2);
        cyc(1, 2'd2, 8'h55, 0, 1, 16'd4);
        cyc(0, 2'd0, 8'h00, 1, 1, 16'd4);
        #1 chk("R9 blocked", 16'({fl_wr, ram_wr}), 16'h0);
        idle(4, 2'd0);
        cyc(1, 2'd0, 8'h00, 0, 1, 16'd4);
        cyc(0, 2'd0, 8'h00, 1, 1, 16'd4);
        #1 chk("R8 ram", 16'({fl_wr, ram_wr}), 16'h1);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [7:0] d;
            logic [15:0] l;
            logic g, x;
            op = int'($urandom % 8);
            d  = 8'($urandom);
            l  = 16'($urandom % 5);
            g  = ($urandom % 4) != 0;
            x  = ($urandom % 3) == 0;
            case (op)
                0: cyc(1, 2'd0, d, x, g, l);
                1: cyc(1, 2'd1, d, x, g, l);
                2, 3: begin
                    case ($urandom % 3)
                        0: d = 8'hAA;
                        1: d = 8'h55;
                        default: ;
                    endcase
                    cyc(1, 2'd2, d, x, g, l);
                end
                default: cyc(0, 2'($urandom), d, x, g, l);
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule